// File: doc/BRIEF.md
# Parallel I/O Port with Bus Register Access

This block is a general-purpose parallel I/O peripheral that sits on a WISHBONE slave bus. Software sets output levels and reads pin levels through a small register window. A parameter picks one of two port styles. In the split style, an input bus and an output bus have independent widths, and outputs are always driven. In the tristate style, every pin drives and samples one shared pad, and a direction register chooses per pin whether the pad is driven.

The data register is as wide as the larger of the two widths. Input bits and output bits share it from bit 0 upward: a read returns the sampled pins, and a write loads the output latch. Each pad is modelled as three plain signals: an input value, an output value and an output enable. Interrupt generation is handled by a separate block and is not part of this one.

Top module: `par_io_port`

## Requirements
- R1: After synchronous reset `rst_i`, `ack_o` is 0, `dat_o` is 0 and `pin_out_o` is 0. In the tristate style `pin_oe_o` is all zeros. In the split style `pin_oe_o` is all ones.
- R2: A request is `cyc_i` and `stb_i` both high while `ack_o` is low. `ack_o` rises at the clock edge that accepts a request, for reads and writes alike. It stays high for exactly one clock. It never rises without a request.
- R3: A write at word offset 0 loads `dat_i[OUT_W-1:0]` into the output latch at the accepting edge, and `pin_out_o` shows the new value from that edge on. Data bits at OUT_W and above are ignored.
- R4: A read at word offset 0 returns the pin inputs in bits [IN_W-1:0] and 0 in all higher bits. The pins pass through SYNC_STAGES (default 2) flops before reaching the read path. So a pin change made one clock before the accepting edge still reads as the old value.
- R5: In the tristate style, word offset 1 is a read/write direction register of OUT_W bits, and reads return 0 above bit OUT_W-1.
- R6: In the tristate style, `pin_oe_o[i]` is 1 (pin driven) when direction bit i is 1. It is 0 (pin is an input) when the bit is 0.
- R7: In the split style, offset 1 reads as 0. A write to offset 1 has no effect, and `pin_oe_o` stays all ones.
- R8: Word offsets 2 and 3 are unmapped. They are acknowledged like any other access, they read as 0, and writes to them change neither `pin_out_o` nor `pin_oe_o`.
- R9: Reset asserted at any time clears the direction register and the output latch, so every tristate pin returns to input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Strobe for this slave |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADR_W | Word address of the register |
| dat_i | input | DAT_W | Write data |
| dat_o | output | DAT_W | Read data, valid while ack_o is high |
| ack_o | output | 1 | One-clock acknowledge |
| pin_in_i | input | IN_W | Pad input values |
| pin_out_o | output | OUT_W | Pad output values |
| pin_oe_o | output | OUT_W | Pad output enables, 1 = driven |

## Verification
The hardest case to reach from the ports is a read that lands while a pin change is still inside the input synchronizer. In that case, the old value must come back even though the pad already shows the new one. The bench reaches this case with a directed step: it changes the pins on a falling edge and issues the read on the very next falling edge. It then reads again and expects the new value. Random traffic runs two instances side by side on the same bus, one in each style. The random traffic mixes accesses to all four offsets, so the unmapped offsets and offset 1 in the split style are exercised between data and direction accesses. A reset in the middle of the run then checks that the direction register is cleared after it has been written.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [0:0] {
    STYLE_SPLIT    = 1'b0,
    STYLE_TRISTATE = 1'b1
  } port_style_e;

  // Word offsets of the register window.
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_DIR  = 1;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pio_bus_ctrl.sv
module pio_bus_ctrl #(
  parameter int unsigned ADR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] adr_i,
  output logic             ack_o,
  output logic             wr_data_o,
  output logic             wr_dir_o,
  output logic             rd_en_o,
  output pio_pkg::reg_sel_e sel_o
);
  import pio_pkg::*;

  logic accept;
  logic ack_q;

  // A request is accepted only while no acknowledge is pending.
  assign accept = cyc_i & stb_i & ~ack_q;

  always_comb begin
    if (adr_i == ADR_W'(OFS_DATA))      sel_o = SEL_DATA;
    else if (adr_i == ADR_W'(OFS_DIR))  sel_o = SEL_DIR;
    else                                sel_o = SEL_NONE;
  end

  assign wr_data_o = accept & we_i & (sel_o == SEL_DATA);
  assign wr_dir_o  = accept & we_i & (sel_o == SEL_DIR);
  assign rd_en_o   = accept & ~we_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) ack_q <= 1'b0;
    else       ack_q <= accept;
  end

  assign ack_o = ack_q;

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q[s] <= '0;
        else       chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q[s] <= '0;
        else       chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pio_out_stage.sv
module pio_out_stage #(
  parameter int unsigned          DAT_W = 32,
  parameter int unsigned          OUT_W = 8,
  parameter pio_pkg::port_style_e STYLE = pio_pkg::STYLE_TRISTATE
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_data_i,
  input  logic             wr_dir_i,
  input  logic [DAT_W-1:0] wdat_i,
  output logic [OUT_W-1:0] dir_o,
  output logic [OUT_W-1:0] pin_out_o,
  output logic [OUT_W-1:0] pin_oe_o
);
  import pio_pkg::*;

  logic [OUT_W-1:0] out_q;

  // Output latch: only the low OUT_W bits of the write word are kept.
  always_ff @(posedge clk_i) begin
    if (rst_i)          out_q <= '0;
    else if (wr_data_i) out_q <= wdat_i[OUT_W-1:0];
  end

  assign pin_out_o = out_q;

  if (STYLE == STYLE_TRISTATE) begin : g_tri
    logic [OUT_W-1:0] dir_q;

    always_ff @(posedge clk_i) begin
      if (rst_i)         dir_q <= '0;
      else if (wr_dir_i) dir_q <= wdat_i[OUT_W-1:0];
    end

    assign dir_o    = dir_q;
    assign pin_oe_o = dir_q;
  end else begin : g_split
    logic unused_dir;
    assign unused_dir = wr_dir_i;
    assign dir_o      = '0;
    assign pin_oe_o   = '1;
  end

endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux #(
  parameter int unsigned DAT_W = 32,
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_en_i,
  input  pio_pkg::reg_sel_e sel_i,
  input  logic [IN_W-1:0]   pins_i,
  input  logic [OUT_W-1:0]  dir_i,
  output logic [DAT_W-1:0]  dat_o
);
  import pio_pkg::*;

  logic [DAT_W-1:0] data_word;
  logic [DAT_W-1:0] dir_word;
  logic [DAT_W-1:0] next_word;
  logic [DAT_W-1:0] dat_q;

  always_comb begin
    data_word = '0;
    data_word[IN_W-1:0] = pins_i;
    dir_word = '0;
    dir_word[OUT_W-1:0] = dir_i;
    unique case (sel_i)
      SEL_DATA: next_word = data_word;
      SEL_DIR:  next_word = dir_word;
      default:  next_word = '0;
    endcase
  end

  // Read data is loaded on an accepted read and cleared otherwise.
  always_ff @(posedge clk_i) begin
    if (rst_i)        dat_q <= '0;
    else if (rd_en_i) dat_q <= next_word;
    else              dat_q <= '0;
  end

  assign dat_o = dat_q;

endmodule

// File: rtl/par_io_port.sv
module par_io_port #(
  parameter pio_pkg::port_style_e STYLE       = pio_pkg::STYLE_TRISTATE,
  parameter int unsigned          IN_W        = 8,
  parameter int unsigned          OUT_W       = 8,
  parameter int unsigned          DAT_W       = 32,
  parameter int unsigned          ADR_W       = 2,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic [DAT_W-1:0] dat_o,
  output logic             ack_o,
  input  logic [IN_W-1:0]  pin_in_i,
  output logic [OUT_W-1:0] pin_out_o,
  output logic [OUT_W-1:0] pin_oe_o
);
  import pio_pkg::*;

  localparam int unsigned REG_W = max_of(IN_W, OUT_W);

  initial begin
    if (REG_W > DAT_W) $error("register width exceeds bus width");
    if (STYLE == STYLE_TRISTATE && IN_W != OUT_W) $error("tristate style needs IN_W == OUT_W");
  end

  logic             wr_data;
  logic             wr_dir;
  logic             rd_en;
  reg_sel_e         sel;
  logic [IN_W-1:0]  pins_sync;
  logic [OUT_W-1:0] dir_val;

  pio_bus_ctrl #(.ADR_W(ADR_W)) u_bus (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cyc_i     (cyc_i),
    .stb_i     (stb_i),
    .we_i      (we_i),
    .adr_i     (adr_i),
    .ack_o     (ack_o),
    .wr_data_o (wr_data),
    .wr_dir_o  (wr_dir),
    .rd_en_o   (rd_en),
    .sel_o     (sel)
  );

  pio_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pin_in_i),
    .q_o   (pins_sync)
  );

  pio_out_stage #(.DAT_W(DAT_W), .OUT_W(OUT_W), .STYLE(STYLE)) u_out (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_data_i (wr_data),
    .wr_dir_i  (wr_dir),
    .wdat_i    (dat_i),
    .dir_o     (dir_val),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );

  pio_rd_mux #(.DAT_W(DAT_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_rd (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rd_en_i (rd_en),
    .sel_i   (sel),
    .pins_i  (pins_sync),
    .dir_i   (dir_val),
    .dat_o   (dat_o)
  );

endmodule

// File: rtl/par_io_port_chk.sv
module par_io_port_chk #(
  parameter pio_pkg::port_style_e STYLE = pio_pkg::STYLE_TRISTATE,
  parameter int unsigned          IN_W  = 8,
  parameter int unsigned          OUT_W = 8,
  parameter int unsigned          DAT_W = 32,
  parameter int unsigned          ADR_W = 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             cyc_i,
  input logic             stb_i,
  input logic             we_i,
  input logic [ADR_W-1:0] adr_i,
  input logic [DAT_W-1:0] dat_i,
  input logic [DAT_W-1:0] dat_o,
  input logic             ack_o,
  input logic [OUT_W-1:0] pin_out_o,
  input logic [OUT_W-1:0] pin_oe_o
);
  import pio_pkg::*;

  logic req;
  assign req = cyc_i & stb_i & ~ack_o;

  // R2: acknowledge lasts one clock
  a_r2_ack_single: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);

  // R2: no acknowledge without a request
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
    !req |=> !ack_o);

  // R2: a request is acknowledged in the next cycle
  a_r2_ack_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    req |=> ack_o);

  // R3: data write reaches the output pins
  a_r3_out_write: assert property (@(posedge clk_i) disable iff (rst_i)
    (req && we_i && adr_i == ADR_W'(OFS_DATA)) |=> pin_out_o == $past(dat_i[OUT_W-1:0]));

  // R3, R8: outputs hold without a data write
  a_r3_out_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !(req && we_i && adr_i == ADR_W'(OFS_DATA)) |=> $stable(pin_out_o));

  // R1, R9: reset clears the output latch
  a_r9_reset_out: assert property (@(posedge clk_i)
    rst_i |=> (pin_out_o == '0 && !ack_o));

  if (IN_W < DAT_W && OUT_W < DAT_W) begin : g_upper
    // R4, R5: bits above the register width read as zero
    a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && $past(!we_i)) |-> dat_o[DAT_W-1:max_of(IN_W, OUT_W)] == '0);
  end

  if (STYLE == STYLE_TRISTATE) begin : g_tri
    // R6: direction write drives the enables
    a_r6_dir_write: assert property (@(posedge clk_i) disable iff (rst_i)
      (req && we_i && adr_i == ADR_W'(OFS_DIR)) |=> pin_oe_o == $past(dat_i[OUT_W-1:0]));
    // R8: enables hold without a direction write
    a_r8_dir_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !(req && we_i && adr_i == ADR_W'(OFS_DIR)) |=> $stable(pin_oe_o));
    // R9: reset makes every pin an input
    a_r9_reset_dir: assert property (@(posedge clk_i)
      rst_i |=> pin_oe_o == '0);
  end else begin : g_split
    // R7: split-style outputs are always driven
    a_r7_oe_on: assert property (@(posedge clk_i) disable iff (rst_i)
      pin_oe_o == '1);
  end

endmodule

bind par_io_port par_io_port_chk #(
  .STYLE(STYLE), .IN_W(IN_W), .OUT_W(OUT_W), .DAT_W(DAT_W), .ADR_W(ADR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cyc_i     (cyc_i),
  .stb_i     (stb_i),
  .we_i      (we_i),
  .adr_i     (adr_i),
  .dat_i     (dat_i),
  .dat_o     (dat_o),
  .ack_o     (ack_o),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o)
);

// File: tb/par_io_port_tb_top.sv
`timescale 1ns/1ps
module par_io_port_tb_top;
  import pio_pkg::*;

  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 2;
  localparam int unsigned TW   = 8;
  localparam int unsigned SIW  = 5;
  localparam int unsigned SOW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc = 1'b0;
  logic          stb = 1'b0;
  logic          we  = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] wdat = '0;

  logic [TW-1:0]  t_in = '0;
  logic [DW-1:0]  t_dat;
  logic           t_ack;
  logic [TW-1:0]  t_out;
  logic [TW-1:0]  t_oe;

  logic [SIW-1:0] s_in = '0;
  logic [DW-1:0]  s_dat;
  logic           s_ack;
  logic [SOW-1:0] s_out;
  logic [SOW-1:0] s_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state kept by the bench
  logic [TW-1:0]  m_tout;
  logic [TW-1:0]  m_dir;
  logic [SOW-1:0] m_sout;

  always #2 clk = ~clk;

  par_io_port #(.STYLE(STYLE_TRISTATE), .IN_W(TW), .OUT_W(TW), .DAT_W(DW), .ADR_W(AW)) dut_i (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .dat_o(t_dat), .ack_o(t_ack),
    .pin_in_i(t_in), .pin_out_o(t_out), .pin_oe_o(t_oe));

  par_io_port #(.STYLE(STYLE_SPLIT), .IN_W(SIW), .OUT_W(SOW), .DAT_W(DW), .ADR_W(AW)) dut_split_i (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .dat_o(s_dat), .ack_o(s_ack),
    .pin_in_i(s_in), .pin_out_o(s_out), .pin_oe_o(s_oe));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read_t(input logic [AW-1:0] a);
    if (a == 2'd0) return {{(DW-TW){1'b0}}, t_in};
    if (a == 2'd1) return {{(DW-TW){1'b0}}, m_dir};
    return '0;
  endfunction

  function automatic logic [DW-1:0] exp_read_s(input logic [AW-1:0] a);
    if (a == 2'd0) return {{(DW-SIW){1'b0}}, s_in};
    return '0;
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (a == 2'd0) begin
      m_tout = d[TW-1:0];
      m_sout = d[SOW-1:0];
    end else if (a == 2'd1) begin
      m_dir = d[TW-1:0];
    end
  endfunction

  // One bus access; both instances see the same request.
  task automatic bus(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] rt, output logic [DW-1:0] rs);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    check(t_ack && s_ack, "R2", "ack one clock after request", {30'd0, t_ack, s_ack}, 32'd3);
    rt = t_dat; rs = s_dat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    if (w) model_write(a, d);
    @(negedge clk);
    check(!t_ack && !s_ack, "R2", "ack drops after one clock", {30'd0, t_ack, s_ack}, 32'd0);
  endtask

  task automatic check_pins(input string req);
    check(t_out == m_tout, req, "tristate pin_out", DW'(t_out), DW'(m_tout));
    check(t_oe == m_dir, req, "tristate pin_oe", DW'(t_oe), DW'(m_dir));
    check(s_out == m_sout, req, "split pin_out", DW'(s_out), DW'(m_sout));
    check(s_oe == '1, "R7", "split pin_oe all ones", DW'(s_oe), DW'({SOW{1'b1}}));
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] rt, rs;
    void'($urandom(32'h5eed_1234));
    m_tout = '0; m_dir = '0; m_sout = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(t_ack == 1'b0 && s_ack == 1'b0, "R1", "ack after reset", {30'd0, t_ack, s_ack}, 32'd0);
    check(t_dat == '0, "R1", "dat_o after reset", t_dat, '0);
    check_pins("R1");

    // R3: data write, bits above OUT_W ignored
    bus(1'b1, 2'd0, 32'hFFFF_F5A3, rt, rs);
    check_pins("R3");

    // R5, R6: direction write and read-back
    bus(1'b1, 2'd1, 32'hFFFF_FFA5, rt, rs);
    check_pins("R6");
    bus(1'b0, 2'd1, '0, rt, rs);
    check(rt == 32'h0000_00A5, "R5", "direction read-back", rt, 32'h0000_00A5);
    check(rs == '0, "R7", "split offset 1 reads zero", rs, '0);

    // R7: split direction write has no effect on enables
    bus(1'b1, 2'd1, 32'h0, rt, rs);
    check_pins("R7");

    // R4: data read with upper bits zero
    t_in = 8'h3C; s_in = 5'h15;
    settle();
    bus(1'b0, 2'd0, '0, rt, rs);
    check(rt == exp_read_t(2'd0), "R4", "tristate data read", rt, exp_read_t(2'd0));
    check(rs == exp_read_s(2'd0), "R4", "split data read", rs, exp_read_s(2'd0));

    // R4: change still inside the synchronizer reads as old value
    @(negedge clk);
    t_in = 8'hC3; s_in = 5'h0A;
    bus(1'b0, 2'd0, '0, rt, rs);
    check(rt == 32'h0000_003C, "R4", "sync latency old tristate value", rt, 32'h0000_003C);
    check(rs == 32'h0000_0015, "R4", "sync latency old split value", rs, 32'h0000_0015);
    bus(1'b0, 2'd0, '0, rt, rs);
    check(rt == 32'h0000_00C3, "R4", "new tristate value", rt, 32'h0000_00C3);
    check(rs == 32'h0000_000A, "R4", "new split value", rs, 32'h0000_000A);

    // R8: unmapped offsets
    bus(1'b1, 2'd2, 32'hFFFF_FFFF, rt, rs);
    bus(1'b1, 2'd3, 32'h0000_0000, rt, rs);
    check_pins("R8");
    bus(1'b0, 2'd3, '0, rt, rs);
    check(rt == '0 && rs == '0, "R8", "unmapped read zero", rt | rs, '0);

    // R2: strobe without cycle is never acknowledged
    @(negedge clk);
    stb = 1'b1; cyc = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!t_ack && !s_ack, "R2", "no ack without cyc", {30'd0, t_ack, s_ack}, 32'd0);
    end
    stb = 1'b0;

    // Random traffic
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      bit w;
      a = AW'($urandom);
      d = $urandom;
      w = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 3) == 0) begin
        t_in = TW'($urandom);
        s_in = SIW'($urandom);
        settle();
      end
      bus(w, a, d, rt, rs);
      if (w) begin
        check_pins(a == 2'd1 ? "R6" : (a == 2'd0 ? "R3" : "R8"));
      end else begin
        check(rt == exp_read_t(a), a == 2'd1 ? "R5" : "R4", "random tristate read", rt, exp_read_t(a));
        check(rs == exp_read_s(a), a == 2'd1 ? "R7" : "R8", "random split read", rs, exp_read_s(a));
      end
    end

    // R9: reset after direction and data were written
    bus(1'b1, 2'd1, 32'h0000_00FF, rt, rs);
    bus(1'b1, 2'd0, 32'h0000_0F0F, rt, rs);
    check_pins("R9");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_tout = '0; m_dir = '0; m_sout = '0;
    @(negedge clk);
    check_pins("R9");
    bus(1'b0, 2'd1, '0, rt, rs);
    check(rt == '0, "R9", "direction reads zero after reset", rt, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule